// File: doc/BRIEF.md
# Forward-Direction Parallel Port Receiver with Run-Length Expansion

This block receives bytes that a host pushes over a bidirectional parallel port running the extended-capability forward protocol. The host places a byte on the data lines and marks it as data or command with its autofeed line. It then pulls its strobe low and waits for the peripheral's busy line. The receiver captures the byte on the synchronised falling edge of strobe and raises busy. It lowers busy only after it has finished with the byte and the host has released strobe. Data bytes leave through a valid/ready byte stream. Command bytes either go to software as a one-cycle event with the command value, or are consumed by the hardware as run-length counts.

A two-bit mode input selects the behaviour. With mode 00, new strobes are ignored. Modes 01 and 10 give plain handshaking, and every command byte reaches software. Mode 11 adds run-length expansion: a command with bit 7 clear holds a count N, and the next data byte is emitted N+1 times. While a count is pending or being expanded, an expansion-active status is high. A one-cycle abort pulse returns the handshake and expansion logic to idle at once. A rewrite of the mode field never cuts short a transfer or expansion that has already started.

The output stream follows the usual back-pressure rules. Once `out_valid_o` rises, it and `out_data_o` stay unchanged until a cycle in which `out_ready_i` is high. A byte moves on each rising clock edge where both are high. The repeat counter advances only on those edges, so a stalled consumer keeps the host blocked through busy.

Top module: `ecp_rx_top`

## Requirements
- R1: With mode 00, a strobe falling edge is ignored: busy stays 0 and no output byte or command event appears.
- R2: In modes 01, 10 and 11, a byte sent with autofeed high (data) and no pending count appears exactly once on the output stream. `out_valid_o` and `out_data_o` stay unchanged while `out_ready_i` is low.
- R3: Busy rises after a captured strobe fall. It stays high while the byte is still being emitted, and drops only after the byte is done and the host strobe has returned high.
- R4: In mode 11, a command byte (autofeed low) with bit 7 = 0 is a count N. It raises no command event, and the next data byte is emitted N+1 times; a count of 0 gives a single byte and 127 gives 128.
- R5: `rld_o` is 1 from the acceptance of a count until the last repeat of the expanded byte has been taken, then returns to 0.
- R6: A command byte with bit 7 = 1 raises `cmd_evt_o` for one cycle with the byte on `cmd_byte_o`. In modes 01 and 10, a command with bit 7 = 0 raises the event as well and is not expanded.
- R7: A mode change during an expansion does not shorten it: all N+1 copies are still emitted.
- R8: An abort pulse clears the output valid, `hold_o`, `rld_o`, the pending count and the internal busy on the next edge. A byte in flight is dropped, and the following data byte is emitted once.
- R9: `busy_o` is the internal busy ORed with `sw_busy_i`, and `ack_o` is the inverse of `sw_ack_i`. With both overrides clear after reset, busy is 0 and ack is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | 00 off, 01/10 handshake, 11 handshake with run-length expansion |
| soft_rst_i | input | 1 | One-cycle abort pulse (register write of the reset bit) |
| sw_busy_i | input | 1 | Software override forcing busy high |
| sw_ack_i | input | 1 | Software override forcing ack low |
| host_strobe_n_i | input | 1 | Host strobe, active low, asynchronous |
| host_autofd_i | input | 1 | Host byte type: 1 data, 0 command |
| host_data_i | input | 8 | Host data lines |
| busy_o | output | 1 | Busy line to host |
| ack_o | output | 1 | Ack line to host |
| out_data_o | output | 8 | Output stream byte |
| out_valid_o | output | 1 | Output stream valid |
| out_ready_i | input | 1 | Output stream ready |
| cmd_evt_o | output | 1 | One-cycle command-received event |
| cmd_byte_o | output | 8 | Last command byte passed to software |
| rld_o | output | 1 | Expansion active (count pending or repeating) |
| hold_o | output | 1 | Output byte waiting for the consumer |

## Verification
The hardest case to reach is a mode rewrite or an abort that lands in the middle of an expansion. The bench holds `out_ready_i` low after sending a count and a data byte, so the expansion is frozen with valid high. It then changes the mode or pulses the abort, and only afterwards releases the stream. A behavioural model keeps queues of expected bytes and commands, and every clock it compares them with the handshakes it observes. Dropped repeats and extra copies therefore show up as mismatches.

// File: rtl/ecp_rx_pkg.sv
package ecp_rx_pkg;
  typedef enum logic [1:0] {
    LK_IDLE  = 2'd0,
    LK_CLASS = 2'd1,
    LK_EMIT  = 2'd2,
    LK_REL   = 2'd3
  } link_st_e;

  localparam logic [1:0] MODE_OFF = 2'b00;
  localparam logic [1:0] MODE_RLE = 2'b11;
endpackage

// File: rtl/ecp_rx_sync.sv
module ecp_rx_sync #(
  parameter int W       = 1,
  parameter int STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= RST_VAL;
        else        chain[s] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= RST_VAL;
        else        chain[s] <= chain[s-1];
      end
    end
  end

  assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/ecp_rx_link.sv
module ecp_rx_link
  import ecp_rx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst_i,
  input  logic [1:0]    mode_i,
  input  logic          strb_s_i,
  input  logic          autofd_i,
  input  logic [DW-1:0] data_i,
  input  logic          exp_done_i,
  output logic          busy_o,
  output logic          data_go_o,
  output logic          cnt_load_o,
  output logic [DW-1:0] byte_o,
  output logic          cmd_evt_o,
  output logic [DW-1:0] cmd_byte_o
);
  link_st_e      st;
  logic          strb_q;
  logic          busy_r;
  logic [DW-1:0] byte_r;
  logic          is_cmd_r;
  logic          rle_r;
  logic          cmd_evt_r;
  logic [DW-1:0] cmd_byte_r;
  logic          fall;
  logic          is_count;

  assign fall     = strb_q & ~strb_s_i;
  assign is_count = is_cmd_r & rle_r & ~byte_r[DW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= LK_IDLE;
      strb_q     <= 1'b1;
      busy_r     <= 1'b0;
      byte_r     <= '0;
      is_cmd_r   <= 1'b0;
      rle_r      <= 1'b0;
      cmd_evt_r  <= 1'b0;
      cmd_byte_r <= '0;
    end else begin
      strb_q    <= strb_s_i;
      cmd_evt_r <= 1'b0;
      if (soft_rst_i) begin
        st     <= LK_IDLE;
        busy_r <= 1'b0;
      end else begin
        unique case (st)
          LK_IDLE: begin
            if (fall && mode_i != MODE_OFF) begin
              byte_r   <= data_i;
              is_cmd_r <= ~autofd_i;
              rle_r    <= (mode_i == MODE_RLE);
              busy_r   <= 1'b1;
              st       <= LK_CLASS;
            end
          end
          LK_CLASS: begin
            if (!is_cmd_r) begin
              st <= LK_EMIT;
            end else begin
              if (!is_count) begin
                cmd_evt_r  <= 1'b1;
                cmd_byte_r <= byte_r;
              end
              st <= LK_REL;
            end
          end
          LK_EMIT: begin
            if (exp_done_i) st <= LK_REL;
          end
          LK_REL: begin
            if (strb_s_i) begin
              busy_r <= 1'b0;
              st     <= LK_IDLE;
            end
          end
          default: st <= LK_IDLE;
        endcase
      end
    end
  end

  assign busy_o     = busy_r;
  assign data_go_o  = (st == LK_CLASS) && !is_cmd_r && !soft_rst_i;
  assign cnt_load_o = (st == LK_CLASS) && is_count && !soft_rst_i;
  assign byte_o     = byte_r;
  assign cmd_evt_o  = cmd_evt_r;
  assign cmd_byte_o = cmd_byte_r;

  AST_OFF_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == LK_IDLE && mode_i == MODE_OFF) |=> !busy_r); // R1

  AST_EVT_NOT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_evt_r |-> (cmd_byte_r[DW-1] || !rle_r)); // R4

  AST_BUSY_UNTIL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == LK_REL && !strb_s_i && !soft_rst_i) |=> busy_r); // R3
endmodule

// File: rtl/ecp_rx_expand.sv
module ecp_rx_expand #(
  parameter int DW = 8,
  localparam int CW = DW - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst_i,
  input  logic          data_go_i,
  input  logic          cnt_load_i,
  input  logic [DW-1:0] byte_i,
  output logic          done_o,
  output logic [DW-1:0] out_data_o,
  output logic          out_valid_o,
  input  logic          out_ready_i,
  output logic          rld_o
);
  logic          pend_vld;
  logic [CW-1:0] pend_cnt;
  logic          vld;
  logic [DW-1:0] obyte;
  logic [CW-1:0] rem;
  logic          take;

  assign take   = vld & out_ready_i;
  assign done_o = take && (rem == '0) && !soft_rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_vld <= 1'b0;
      pend_cnt <= '0;
      vld      <= 1'b0;
      obyte    <= '0;
      rem      <= '0;
    end else if (soft_rst_i) begin
      pend_vld <= 1'b0;
      pend_cnt <= '0;
      vld      <= 1'b0;
      rem      <= '0;
    end else begin
      if (cnt_load_i) begin
        pend_vld <= 1'b1;
        pend_cnt <= byte_i[CW-1:0];
      end
      if (data_go_i) begin
        vld   <= 1'b1;
        obyte <= byte_i;
        rem   <= pend_vld ? pend_cnt : '0;
      end else if (take) begin
        if (rem == '0) begin
          vld      <= 1'b0;
          pend_vld <= 1'b0;
        end else begin
          rem <= rem - 1'b1;
        end
      end
    end
  end

  assign out_data_o  = obyte;
  assign out_valid_o = vld;
  assign rld_o       = pend_vld;

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && !out_ready_i && !soft_rst_i) |=> (vld && $stable(obyte))); // R2

  AST_RLD_COVERS_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && rem != '0) |-> pend_vld); // R5

  AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_i |=> (!vld && !pend_vld)); // R8
endmodule

// File: rtl/ecp_rx_top.sv
module ecp_rx_top #(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode_i,
  input  logic          soft_rst_i,
  input  logic          sw_busy_i,
  input  logic          sw_ack_i,
  input  logic          host_strobe_n_i,
  input  logic          host_autofd_i,
  input  logic [DW-1:0] host_data_i,
  output logic          busy_o,
  output logic          ack_o,
  output logic [DW-1:0] out_data_o,
  output logic          out_valid_o,
  input  logic          out_ready_i,
  output logic          cmd_evt_o,
  output logic [DW-1:0] cmd_byte_o,
  output logic          rld_o,
  output logic          hold_o
);
  logic          strb_s;
  logic          busy_int;
  logic          data_go;
  logic          cnt_load;
  logic [DW-1:0] cap_byte;
  logic          exp_done;

  ecp_rx_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (host_strobe_n_i),
    .sync_o  (strb_s)
  );

  ecp_rx_link #(.DW(DW)) u_link (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst_i (soft_rst_i),
    .mode_i     (mode_i),
    .strb_s_i   (strb_s),
    .autofd_i   (host_autofd_i),
    .data_i     (host_data_i),
    .exp_done_i (exp_done),
    .busy_o     (busy_int),
    .data_go_o  (data_go),
    .cnt_load_o (cnt_load),
    .byte_o     (cap_byte),
    .cmd_evt_o  (cmd_evt_o),
    .cmd_byte_o (cmd_byte_o)
  );

  ecp_rx_expand #(.DW(DW)) u_exp (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_rst_i  (soft_rst_i),
    .data_go_i   (data_go),
    .cnt_load_i  (cnt_load),
    .byte_i      (cap_byte),
    .done_o      (exp_done),
    .out_data_o  (out_data_o),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .rld_o       (rld_o)
  );

  // The forward direction never drives ack itself; only the override can.
  assign busy_o = busy_int | sw_busy_i;
  assign ack_o  = ~sw_ack_i;
  assign hold_o = out_valid_o;

  AST_BUSY_WHILE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> busy_int); // R3
endmodule

// File: tb/sim_ecp_rx_top.sv
module sim_ecp_rx_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       soft_rst = 1'b0;
  logic       sw_busy = 1'b0;
  logic       sw_ack = 1'b0;
  logic       strobe_n = 1'b1;
  logic       autofd = 1'b1;
  logic [7:0] hdata = 8'h00;
  logic       busy, ack, ovalid, cmd_evt, rld, hold;
  logic [7:0] odata, cmd_byte;
  logic       rdy = 1'b0;

  always #5 clk = ~clk;

  ecp_rx_top u0 (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .soft_rst_i(soft_rst),
    .sw_busy_i(sw_busy), .sw_ack_i(sw_ack), .host_strobe_n_i(strobe_n),
    .host_autofd_i(autofd), .host_data_i(hdata), .busy_o(busy), .ack_o(ack),
    .out_data_o(odata), .out_valid_o(ovalid), .out_ready_i(rdy),
    .cmd_evt_o(cmd_evt), .cmd_byte_o(cmd_byte), .rld_o(rld), .hold_o(hold)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int ready_mode = 0;
  logic [7:0] lfsr = 8'hA5;
  logic [7:0] exp_q[$];
  logic [7:0] cmd_q[$];
  bit   pend_v = 0;
  int   pend_n = 0;
  bit   prev_v = 0, prev_r = 0, prev_sr = 0;
  logic [7:0] prev_d = 0;
  bit   done = 0;

  task automatic chk(bit ok, string req, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Behavioural model and per-clock comparison
  always @(negedge clk) begin
    if (rst_n && !done) begin
      cyc++;
      if (cyc > 150000) begin
        chk(0, "WDOG", "watchdog expired", cyc, 0);
        done = 1;
        finish_run();
      end
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      case (ready_mode)
        0: rdy = 1'b1;
        1: rdy = lfsr[0];
        default: rdy = 1'b0;
      endcase
      if (prev_v && !prev_r && !prev_sr) begin
        chk(ovalid == 1'b1, "R2", "valid dropped under back-pressure", ovalid, 1);
        chk(odata == prev_d, "R2", "data changed under back-pressure", odata, prev_d);
      end
      if (ovalid && rdy) begin
        if (exp_q.size() == 0) chk(0, "R2", "unexpected output byte", odata, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(odata == e, "R4", "output byte", odata, e);
        end
      end
      if (cmd_evt) begin
        if (cmd_q.size() == 0) chk(0, "R6", "unexpected command event", cmd_byte, 0);
        else begin
          logic [7:0] c;
          c = cmd_q.pop_front();
          chk(cmd_byte == c, "R6", "command byte", cmd_byte, c);
        end
      end
      prev_v = ovalid; prev_r = rdy; prev_d = odata; prev_sr = soft_rst;
    end
  end

  task automatic host_drive(bit cmd, logic [7:0] b);
    @(negedge clk);
    hdata = b;
    autofd = !cmd;
    @(negedge clk);
    strobe_n = 1'b0;
    if (mode != 2'b00) begin
      if (cmd) begin
        if (mode == 2'b11 && !b[7]) begin pend_v = 1; pend_n = b; end
        else cmd_q.push_back(b);
      end else begin
        int reps;
        reps = pend_v ? pend_n + 1 : 1;
        for (int i = 0; i < reps; i++) exp_q.push_back(b);
        pend_v = 0;
      end
      begin
        bit seen;
        seen = 0;
        for (int i = 0; i < 12 && !seen; i++) begin
          @(negedge clk);
          if (busy) seen = 1;
        end
        chk(seen, "R3", "busy after strobe fall", seen, 1);
      end
    end
  endtask

  task automatic host_release();
    @(negedge clk);
    strobe_n = 1'b1;
  endtask

  task automatic wait_idle(string req);
    bit fin;
    fin = 0;
    for (int i = 0; i < 4000 && !fin; i++) begin
      @(negedge clk);
      if (!busy) fin = 1;
    end
    chk(fin, req, "busy returned low", busy, 0);
  endtask

  task automatic send(bit cmd, logic [7:0] b, string req);
    host_drive(cmd, b);
    host_release();
    wait_idle(req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0, "R9", "reset busy", busy, 0);
    chk(ack == 1, "R9", "reset ack", ack, 1);
    chk(ovalid == 0 && hold == 0 && rld == 0, "R8", "reset status", {ovalid, hold, rld}, 0);

    // R1: mode off ignores strobe
    mode = 2'b00;
    host_drive(0, 8'h55);
    repeat (8) @(negedge clk);
    chk(busy == 0, "R1", "busy with mode off", busy, 0);
    chk(ovalid == 0, "R1", "output with mode off", ovalid, 0);
    host_release();
    repeat (5) @(negedge clk);

    // R2: plain data, free-flowing then back-pressured
    mode = 2'b01; ready_mode = 0;
    send(0, 8'hA1, "R2");
    send(0, 8'hA2, "R2");
    mode = 2'b10; ready_mode = 1;
    send(0, 8'h10, "R2");
    send(0, 8'h20, "R2");
    send(0, 8'h30, "R2");

    // R6: commands in plain mode are all reported
    send(1, 8'h05, "R6");
    send(1, 8'h83, "R6");
    repeat (3) @(negedge clk);

    // R4 / R5 / R3: count then stalled data
    mode = 2'b11; ready_mode = 2;
    send(1, 8'h04, "R4");
    chk(rld == 1, "R5", "rld after count", rld, 1);
    host_drive(0, 8'h3C);
    host_release();
    repeat (10) @(negedge clk);
    chk(ovalid == 1, "R2", "valid held while stalled", ovalid, 1);
    chk(busy == 1, "R3", "busy while repeats pending", busy, 1);
    chk(rld == 1, "R5", "rld during expansion", rld, 1);
    ready_mode = 1;
    wait_idle("R4");
    repeat (2) @(negedge clk);
    chk(rld == 0, "R5", "rld after expansion", rld, 0);
    chk(exp_q.size() == 0, "R4", "repeats outstanding", exp_q.size(), 0);

    // R6: channel address in expansion mode
    send(1, 8'h9A, "R6");

    // R7: mode rewrite during expansion
    ready_mode = 2;
    send(1, 8'h02, "R7");
    host_drive(0, 8'hE7);
    host_release();
    repeat (8) @(negedge clk);
    mode = 2'b01;
    ready_mode = 0;
    wait_idle("R7");
    chk(exp_q.size() == 0, "R7", "copies lost after mode change", exp_q.size(), 0);
    send(1, 8'h01, "R6");
    repeat (3) @(negedge clk);

    // R4 boundaries: count 0 and count 127
    mode = 2'b11;
    send(1, 8'h00, "R4");
    send(0, 8'h11, "R4");
    send(1, 8'h7F, "R4");
    send(0, 8'hC3, "R4");
    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R4", "max count copies", exp_q.size(), 0);

    // R8: abort mid-expansion
    ready_mode = 2;
    send(1, 8'h06, "R8");
    host_drive(0, 8'h77);
    for (int i = 0; i < 20 && !ovalid; i++) @(negedge clk);
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    exp_q.delete();
    pend_v = 0;
    chk(ovalid == 0 && hold == 0, "R8", "valid/hold after abort", {ovalid, hold}, 0);
    chk(rld == 0, "R8", "rld after abort", rld, 0);
    chk(busy == 0, "R8", "busy after abort", busy, 0);
    host_release();
    ready_mode = 0;
    repeat (10) @(negedge clk);
    send(0, 8'h42, "R8");
    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R8", "byte after abort", exp_q.size(), 0);

    // R9: overrides
    sw_busy = 1'b1;
    @(negedge clk);
    chk(busy == 1, "R9", "busy override", busy, 1);
    sw_ack = 1'b1;
    @(negedge clk);
    chk(ack == 0, "R9", "ack override", ack, 0);
    sw_busy = 1'b0; sw_ack = 1'b0;
    @(negedge clk);
    chk(busy == 0 && ack == 1, "R9", "overrides released", {busy, ack}, 1);

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0 && cmd_q.size() == 0, "R6", "leftover expectations",
        exp_q.size() + cmd_q.size(), 0);
    done = 1;
    finish_run();
  end
endmodule